// File: doc/BRIEF.md
# Dual-Channel Out-of-Range Detector

This block watches the sample streams of two 14-bit converter channels and raises one out-of-range flag per channel. Each channel takes one two's-complement sample per clock together with an overflow indication from the converter core. The two channels share one clock, one reset and one configuration, but each is detected and timed on its own.

Two detection paths run side by side in every channel. The slow path flags samples that sit at a code extreme or arrive with the overflow input high, and delivers the flag after 14 cycles. The fast path compares the sample magnitude against one of eight thresholds below full scale and delivers the flag after only 4 cycles. A static enable picks the path, and a 3-bit select picks the threshold. Both settings travel with each sample, so a change affects only samples that enter after it.

Top module: `oor_dual_detector`

## Requirements
- R1: While `rst_n` is low both outputs are low, and no sample that entered before reset can raise an output after reset is released.
- R2: With `fast_en` low, a qualifying sample presented in cycle t raises its channel's output in cycle t+14 only, for exactly that one cycle.
- R3: With `fast_en` low, a sample qualifies if its code is 8191 (14'h1FFF) or -8192 (14'h2000), or if that channel's overflow input is high in the same cycle.
- R4: With `fast_en` low, any other code with the overflow input low raises no flag, and the threshold select has no effect.
- R5: With `fast_en` high, a sample whose magnitude is greater than or equal to the selected threshold raises its channel's output in cycle t+4 only; the overflow input and the code-extreme rule are not used.
- R6: The threshold select values 0 to 7 map to magnitudes 768, 1280, 2304, 3328, 4352, 5376, 6400 and 7424 (about -20.6 dB up to -0.9 dB below full scale).
- R7: The magnitude is the absolute value of the sample, with -8192 treated as 8191.
- R8: A sample on one channel never affects the other channel's output.
- R9: A change of `fast_en` applies to samples entering from that cycle on; samples already in flight still come out with the latency of the mode they entered under.
- R10: A change of `thr_sel` applies to the sample presented in the same cycle and later ones only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| fast_en | input | 1 | 1 selects threshold detection with short latency, 0 selects overflow detection with long latency |
| thr_sel | input | 3 | Threshold code for the fast path |
| samp_a | input | 14 | Channel A two's-complement sample |
| ovf_a | input | 1 | Channel A overflow indication from the core |
| samp_b | input | 14 | Channel B two's-complement sample |
| ovf_b | input | 1 | Channel B overflow indication from the core |
| oor_a | output | 1 | Channel A out-of-range flag |
| oor_b | output | 1 | Channel B out-of-range flag |

## Verification
A corrupted pipeline stage shows as a flag that arrives one cycle early or late, that is lost, or that appears with no cause, and it reaches the port no later than 14 cycles after the sample that entered the stage. A wrong threshold constant or magnitude shows as a missing or extra flag exactly 4 cycles after a sample placed one count on either side of that threshold. A mode or select that is not carried with the sample shows in the cycles right after a configuration change, as a flag that comes with the wrong latency or is lost.

// File: rtl/oor_pkg.sv
package oor_pkg;

  localparam int unsigned SEL_W  = 3;
  localparam int unsigned BASE_W = 14;

  // Threshold magnitude for a select code, scaled from the 14-bit base.
  function automatic int unsigned fast_thr(input logic [SEL_W-1:0] sel,
                                           input int unsigned samp_w);
    int unsigned base;
    case (sel)
      3'd0:    base = 768;
      3'd1:    base = 1280;
      3'd2:    base = 2304;
      3'd3:    base = 3328;
      3'd4:    base = 4352;
      3'd5:    base = 5376;
      3'd6:    base = 6400;
      default: base = 7424;
    endcase
    return base << (samp_w - BASE_W);
  endfunction

endpackage

// File: rtl/oor_mag_cmp.sv
module oor_mag_cmp #(
  parameter int unsigned SAMP_W = 14
) (
  input  logic [SAMP_W-1:0] samp_i,
  input  logic [SAMP_W-2:0] thr_i,
  output logic              ge_o,
  output logic              extreme_o
);

  localparam int unsigned MAG_W = SAMP_W - 1;
  localparam logic [SAMP_W-1:0] CODE_MAX = {1'b0, {MAG_W{1'b1}}};
  localparam logic [SAMP_W-1:0] CODE_MIN = {1'b1, {MAG_W{1'b0}}};

  logic [SAMP_W-1:0] neg;
  logic [MAG_W-1:0]  mag;

  always_comb begin
    neg = ~samp_i + SAMP_W'(1);
    if (!samp_i[SAMP_W-1]) begin
      mag = samp_i[MAG_W-1:0];
    end else if (samp_i == CODE_MIN) begin
      mag = {MAG_W{1'b1}};
    end else begin
      mag = neg[MAG_W-1:0];
    end
  end

  assign ge_o      = (mag >= thr_i);
  assign extreme_o = (samp_i == CODE_MAX) || (samp_i == CODE_MIN);

endmodule

// File: rtl/oor_delay_line.sv
module oor_delay_line #(
  parameter int unsigned DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [DEPTH-1:0] stage_q;
  logic [DEPTH-1:0] stage_d;

  generate
    if (DEPTH == 1) begin : g_single
      always_comb stage_d = d_i;
    end else begin : g_multi
      always_comb stage_d = {stage_q[DEPTH-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign q_o = stage_q[DEPTH-1];

endmodule

// File: rtl/oor_channel.sv
module oor_channel #(
  parameter int unsigned SAMP_W   = 14,
  parameter int unsigned NORM_LAT = 14,
  parameter int unsigned FAST_LAT = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fast_en_i,
  input  logic [oor_pkg::SEL_W-1:0] thr_sel_i,
  input  logic [SAMP_W-1:0]        samp_i,
  input  logic                     ovf_i,
  output logic                     oor_o
);

  localparam int unsigned MAG_W = SAMP_W - 1;
  localparam int unsigned AGE_W = $clog2(NORM_LAT + 1);

  logic [MAG_W-1:0] thr;
  logic             ge;
  logic             extreme;
  logic             fast_hit;
  logic             norm_hit;
  logic             fast_tail;
  logic             norm_tail;
  logic             oor_d;
  logic             oor_q;
  logic [AGE_W-1:0] age_d;
  logic [AGE_W-1:0] age_q;

  assign thr = MAG_W'(oor_pkg::fast_thr(thr_sel_i, SAMP_W));

  oor_mag_cmp #(.SAMP_W(SAMP_W)) mag_i (
    .samp_i    (samp_i),
    .thr_i     (thr),
    .ge_o      (ge),
    .extreme_o (extreme)
  );

  // The mode is folded into each entry flag so it travels with the sample.
  assign fast_hit = fast_en_i & ge;
  assign norm_hit = ~fast_en_i & (extreme | ovf_i);

  oor_delay_line #(.DEPTH(FAST_LAT - 1)) fast_dl_i (
    .clk (clk), .rst_n (rst_n), .d_i (fast_hit), .q_o (fast_tail)
  );

  oor_delay_line #(.DEPTH(NORM_LAT - 1)) norm_dl_i (
    .clk (clk), .rst_n (rst_n), .d_i (norm_hit), .q_o (norm_tail)
  );

  always_comb oor_d = fast_tail | norm_tail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oor_q <= 1'b0;
    end else begin
      oor_q <= oor_d;
    end
  end

  assign oor_o = oor_q;

  // Cycles since reset release, saturating; bounds the assertion windows.
  always_comb age_d = (age_q == AGE_W'(NORM_LAT)) ? age_q : age_q + AGE_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
    end else begin
      age_q <= age_d;
    end
  end

  generate
    if (FAST_LAT == 4 && NORM_LAT == 14) begin : g_chk
      // R5: a fast-mode hit reaches the output four cycles later
      p_fast_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= AGE_W'(4) && $past(fast_hit, 4)) |-> oor_o);
      // R2: a normal-mode hit reaches the output fourteen cycles later
      p_norm_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= AGE_W'(14) && $past(norm_hit, 14)) |-> oor_o);
      // R3: a code extreme in normal mode is always flagged
      p_extreme_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= AGE_W'(14) && $past(extreme & ~fast_en_i, 14)) |-> oor_o);
      // R4: no cause in either window means no flag
      p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= AGE_W'(14) && !$past(fast_hit, 4) && !$past(norm_hit, 14))
        |-> !oor_o);
    end
  endgenerate

endmodule

// File: rtl/oor_dual_detector.sv
module oor_dual_detector #(
  parameter int unsigned SAMP_W   = 14,
  parameter int unsigned NORM_LAT = 14,
  parameter int unsigned FAST_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_en,
  input  logic [2:0]        thr_sel,
  input  logic [SAMP_W-1:0] samp_a,
  input  logic              ovf_a,
  input  logic [SAMP_W-1:0] samp_b,
  input  logic              ovf_b,
  output logic              oor_a,
  output logic              oor_b
);

  localparam int unsigned N_CH = 2;

  logic [SAMP_W-1:0] samp [N_CH];
  logic [N_CH-1:0]   ovf;
  logic [N_CH-1:0]   oor;

  assign samp[0] = samp_a;
  assign samp[1] = samp_b;
  assign ovf     = {ovf_b, ovf_a};

  generate
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
      oor_channel #(
        .SAMP_W   (SAMP_W),
        .NORM_LAT (NORM_LAT),
        .FAST_LAT (FAST_LAT)
      ) chan_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fast_en_i (fast_en),
        .thr_sel_i (thr_sel),
        .samp_i    (samp[ch]),
        .ovf_i     (ovf[ch]),
        .oor_o     (oor[ch])
      );
    end
  endgenerate

  assign oor_a = oor[0];
  assign oor_b = oor[1];

  // R1: outputs held low while reset is applied
  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_low_r1: assert (oor == '0);
    end
  end

endmodule

// File: tb/oor_dual_detector_tb_top.sv
module oor_dual_detector_tb_top;

  logic        clk;
  logic        rst_n;
  logic        fast_en;
  logic [2:0]  thr_sel;
  logic [13:0] samp_a, samp_b;
  logic        ovf_a, ovf_b;
  logic        oor_a, oor_b;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;

  bit    exp_a [0:1023];
  bit    exp_b [0:1023];
  string tag_a [0:1023];
  string tag_b [0:1023];

  oor_dual_detector dut_i (
    .clk (clk), .rst_n (rst_n), .fast_en (fast_en), .thr_sel (thr_sel),
    .samp_a (samp_a), .ovf_a (ovf_a), .samp_b (samp_b), .ovf_b (ovf_b),
    .oor_a (oor_a), .oor_b (oor_b)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic        f;
    logic [2:0]  t;
    logic [13:0] sa;
    logic        oa;
    logic [13:0] sb;
    logic        ob;
    logic        ea;
    logic        eb;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd0, 14'd8191,      1'b0, 14'd0,         1'b0, 1'b1, 1'b0}, // R3 max
    '{1'b0, 3'd0, 14'h2000,      1'b0, 14'd8190,      1'b0, 1'b1, 1'b0}, // R3 min, R4
    '{1'b0, 3'd0, 14'd100,       1'b0, 14'd100,       1'b1, 1'b0, 1'b1}, // R3 ovf, R8
    '{1'b0, 3'd0, 14'(-8191),    1'b0, 14'(-8191),    1'b0, 1'b0, 1'b0}, // R4
    '{1'b0, 3'd7, 14'd8190,      1'b0, 14'd0,         1'b0, 1'b0, 1'b0}, // R4 sel ignored
    '{1'b1, 3'd0, 14'd768,       1'b0, 14'd767,       1'b0, 1'b1, 1'b0}, // R6 code 0
    '{1'b1, 3'd0, 14'(-767),     1'b0, 14'(-768),     1'b0, 1'b0, 1'b1}, // R7
    '{1'b1, 3'd1, 14'd1280,      1'b0, 14'd1279,      1'b0, 1'b1, 1'b0}, // R6 code 1
    '{1'b1, 3'd2, 14'd2303,      1'b0, 14'(-2304),    1'b0, 1'b0, 1'b1}, // R6 code 2
    '{1'b1, 3'd3, 14'(-3328),    1'b0, 14'd3327,      1'b0, 1'b1, 1'b0}, // R6 code 3
    '{1'b1, 3'd4, 14'd4351,      1'b0, 14'd4352,      1'b0, 1'b0, 1'b1}, // R6 code 4
    '{1'b1, 3'd5, 14'd5376,      1'b0, 14'(-5375),    1'b0, 1'b1, 1'b0}, // R6 code 5
    '{1'b1, 3'd6, 14'd6399,      1'b0, 14'd6400,      1'b0, 1'b0, 1'b1}, // R6 code 6
    '{1'b1, 3'd7, 14'd7424,      1'b0, 14'(-7423),    1'b0, 1'b1, 1'b0}, // R6 code 7
    '{1'b1, 3'd7, 14'h2000,      1'b0, 14'd8191,      1'b0, 1'b1, 1'b1}, // R7 saturation
    '{1'b1, 3'd7, 14'd0,         1'b1, 14'd0,         1'b1, 1'b0, 1'b0}, // R5 ovf unused
    '{1'b1, 3'd0, 14'd0,         1'b0, 14'(-1),       1'b0, 1'b0, 1'b0}  // R5 small
  };

  // Expected flag, taken from the requirements.
  function automatic bit model_hit(input logic [13:0] s, input logic o,
                                   input logic f, input logic [2:0] t);
    int v, m;
    int thr_tbl [8] = '{768, 1280, 2304, 3328, 4352, 5376, 6400, 7424};
    v = int'($signed(s));
    m = (v < 0) ? -v : v;
    if (m > 8191) m = 8191;
    if (f) return m >= thr_tbl[t];
    return (v == 8191) || (v == -8192) || o;
  endfunction

  task automatic check_now();
    string ta, tb_;
    ta  = (tag_a[cyc] == "") ? "R4/R8 no flag" : tag_a[cyc];
    tb_ = (tag_b[cyc] == "") ? "R4/R8 no flag" : tag_b[cyc];
    checks += 2;
    if (oor_a !== exp_a[cyc]) begin
      errors++;
      $display("FAIL %s chan A cycle %0d: got %b expected %b", ta, cyc, oor_a, exp_a[cyc]);
    end
    if (oor_b !== exp_b[cyc]) begin
      errors++;
      $display("FAIL %s chan B cycle %0d: got %b expected %b", tb_, cyc, oor_b, exp_b[cyc]);
    end
  endtask

  task automatic step(input logic [13:0] sa, input logic oa, input logic [13:0] sb,
                      input logic ob, input logic f, input logic [2:0] t,
                      input bit ea, input bit eb, input string tg);
    int lat;
    @(negedge clk);
    check_now();
    samp_a = sa; ovf_a = oa; samp_b = sb; ovf_b = ob; fast_en = f; thr_sel = t;
    lat = f ? 4 : 14;
    if (ea) begin exp_a[cyc+lat] = 1'b1; tag_a[cyc+lat] = tg; end
    if (eb) begin exp_b[cyc+lat] = 1'b1; tag_b[cyc+lat] = tg; end
    cyc++;
  endtask

  task automatic mstep(input logic [13:0] sa, input logic [13:0] sb,
                       input logic f, input logic [2:0] t, input string tg);
    step(sa, 1'b0, sb, 1'b0, f, t, model_hit(sa, 1'b0, f, t),
         model_hit(sb, 1'b0, f, t), tg);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(14'd0, 1'b0, 14'd0, 1'b0, 1'b0, 3'd0, 0, 0, "");
  endtask

  task automatic check_low(input string tg);
    checks++;
    if (oor_a !== 1'b0 || oor_b !== 1'b0) begin
      errors++;
      $display("FAIL %s: got %b%b expected 00", tg, oor_a, oor_b);
    end
  endtask

  initial begin
    rst_n = 1'b0; fast_en = 1'b0; thr_sel = 3'd0;
    samp_a = 14'd8191; samp_b = 14'h2000; ovf_a = 1'b1; ovf_b = 1'b1;
    // R1: reset holds outputs low despite extreme inputs
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i > 0) check_low("R1 during reset");
    end
    samp_a = 14'd0; samp_b = 14'd0; ovf_a = 1'b0; ovf_b = 1'b0;
    rst_n = 1'b1;

    // Vector table: R2 R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      step(VECS[v].sa, VECS[v].oa, VECS[v].sb, VECS[v].ob, VECS[v].f, VECS[v].t,
           VECS[v].ea, VECS[v].eb, VECS[v].f ? "R5/R6 fast" : "R2/R3 normal");
    end
    idle(16);

    // R9: normal-mode hit in flight, then switch to fast
    mstep(14'd8191, 14'd0, 1'b0, 3'd7, "R9 normal in flight");
    mstep(14'd8000, 14'd0, 1'b1, 3'd7, "R9 fast after switch");
    mstep(14'd0,    14'd0, 1'b1, 3'd7, "R9");
    idle(16);
    // R9: fast hit in flight, then switch back to normal
    mstep(14'd0, 14'd7500, 1'b1, 3'd7, "R9 fast in flight");
    mstep(14'd0, 14'h2000, 1'b0, 3'd0, "R9 normal after switch");
    idle(16);

    // R10: select change applies per sample
    mstep(14'd7000, 14'd7000, 1'b1, 3'd7, "R10 high threshold");
    mstep(14'd7000, 14'd7000, 1'b1, 3'd0, "R10 low threshold");
    mstep(14'd2000, 14'(-2000), 1'b1, 3'd2, "R10 code 2");
    mstep(14'd2000, 14'(-2000), 1'b1, 3'd1, "R10 code 1");
    idle(16);

    // R8: one channel busy every cycle, the other idle
    for (int i = 0; i < 6; i++) mstep(14'd8191, 14'd8190, 1'b0, 3'd0, "R8 normal");
    for (int i = 0; i < 6; i++) mstep(14'd10, 14'(-7424), 1'b1, 3'd7, "R8 fast");
    idle(16);

    // R1: hits in flight are discarded by reset
    step(14'd8191, 1'b0, 14'd8191, 1'b0, 1'b0, 3'd0, 0, 0, "R1");
    step(14'd8191, 1'b0, 14'd8191, 1'b0, 1'b1, 3'd0, 0, 0, "R1");
    idle(2);
    rst_n = 1'b0;
    @(negedge clk);
    check_low("R1 reset mid-flight");
    @(negedge clk);
    check_low("R1 reset mid-flight");
    rst_n = 1'b1;
    idle(16);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule